// File: doc/BRIEF.md
# Programmable Sink-Current Port Controller

This block is the digital control for an eight-pin port. Each pin's low level is a current sink whose strength can be programmed. For every pin it holds a data bit, a 4-bit sink-strength code, an interrupt enable and an edge-polarity bit. From these it drives three sets of controls for an analog pad cell that sits outside the block:

- a pull-up enable,
- a sink enable,
- the 4-bit sink code.

It also drives a fixed per-pin range flag. That flag marks the two lowest pins as the high-current group.

Writing 1 to a pin's data bit turns on the pull-up and turns off the sink. The pin then idles high and can be used as an input. Writing 0 turns off the pull-up and enables the sink at that pin's programmed strength. The pin levels come back through a synchronizer. A selected edge on a pin sets a sticky pending bit, and software clears that bit by writing 1 to it. The port interrupt is raised when the global enable is on and at least one enabled pin is pending.

The block uses a simple register bus: single-cycle writes, and registered reads that return their data one cycle after the read strobe. With the default of eight pins, the address map is:

| Address | Contents |
|---|---|
| 0–7 | Sink-strength codes |
| 8 | Data |
| 9 | Interrupt enable |
| 10 | Polarity |
| 11 | Pending |
| 12 | Pin level |
| 13 | Global enable |

Top module: `sink_port_ctrl`

## Requirements
- R1: A write of 1 to bit i of the data register (address 8) sets pu_en[i] to 1 on the second clock edge after the write edge, and keeps it there until bit i is written again.
- R2: A write of 0 to data bit i sets snk_en[i] to 1 and pu_en[i] to 0 with the same timing as R1. snk_en is always the inverse of the data bit.
- R3: Synchronous reset leaves the registers in this state: data all ones, all sink codes 0, interrupt enables 0, polarities 0, pending bits 0, global enable 0. After reset, pu_en is all ones, snk_en and snk_code are 0, irq is 0 and rdata is 0.
- R4: Address i (0..7) holds pin i's 4-bit sink code in bits 3:0, and bits 7:4 of a write there are ignored. The code appears on snk_code[4i+3:4i] two edges after the write, and reads back with bits 7:4 as 0.
- R5: hi_range[i] is 1 for pins 0 and 1 and 0 for pins 2..7, at all times.
- R6: The pin-level register (address 12) returns pin_in after a two-stage synchronizer. A pin whose data bit is 1 keeps its pull-up on, so it can be used as an input.
- R7: Polarity bit i (address 10) selects the edge that sets pending bit i: 1 selects a rising edge of the synchronized level and 0 selects a falling edge. The opposite edge sets nothing.
- R8: Pending bits (address 11) are set by a selected edge whatever the enables are. They stay set until a write of 1 to the same bit position, and a new edge in the clearing cycle wins over the clear.
- R9: irq is a register that is 1 exactly when, on the previous edge, global enable (address 13, bit 0) was 1 and some pending bit with its enable bit (address 9) set was 1.
- R10: rdata is a register. It returns the addressed register one cycle after rd_en and is 0 in any cycle after which no read was made. Addresses 14 and 15 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Asynchronous pin levels from the pads |
| pu_en | output | 8 | Per-pin pull-up enable |
| snk_en | output | 8 | Per-pin current-sink enable |
| snk_code | output | 32 | Per-pin 4-bit sink strength, pin i at bits 4i+3:4i |
| hi_range | output | 8 | Per-pin high-current group flag |
| irq | output | 1 | Port interrupt |

## Verification
A wrong data or code register shows up on pu_en, snk_en or snk_code within two edges of the write that set it. A stale synchronizer stage or previous-level register shows up as a pending bit that is missing or spurious. That error is visible on irq one edge after the pending update, and on a pending read one cycle after the strobe. The bench keeps its own model of every register and of the pin history, and compares all outputs on each falling edge. A lost clear, a clear that beats a simultaneous edge, or a polarity that is inverted is therefore caught in the cycle it first becomes visible.

// File: rtl/sink_port_pkg.sv
package sink_port_pkg;
  // Offsets of the control registers above the per-pin strength codes
  localparam int OFS_DATA = 0;
  localparam int OFS_IEN  = 1;
  localparam int OFS_POL  = 2;
  localparam int OFS_PEND = 3;
  localparam int OFS_LVL  = 4;
  localparam int OFS_GEN  = 5;
  localparam int N_CTRL   = 6;

  function automatic int addr_bits(input int npin);
    return $clog2(npin + N_CTRL);
  endfunction
endpackage

// File: rtl/sink_port_regs.sv
module sink_port_regs
  import sink_port_pkg::*;
#(
  parameter int NPIN   = 8,
  parameter int CODE_W = 4,
  parameter int BUS_W  = 8,
  parameter int ADDR_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [BUS_W-1:0]         wdata,
  input  logic [NPIN-1:0]          lvl_i,
  input  logic [NPIN-1:0]          pend_i,
  output logic [NPIN-1:0]          data_q,
  output logic [NPIN-1:0]          ien_q,
  output logic [NPIN-1:0]          pol_q,
  output logic                     gen_q,
  output logic [NPIN-1:0]          clr_o,
  output logic [NPIN*CODE_W-1:0]   code_flat,
  output logic [BUS_W-1:0]         rdata
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(NPIN + OFS_DATA);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(NPIN + OFS_IEN);
  localparam logic [ADDR_W-1:0] A_POL  = ADDR_W'(NPIN + OFS_POL);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(NPIN + OFS_PEND);
  localparam logic [ADDR_W-1:0] A_LVL  = ADDR_W'(NPIN + OFS_LVL);
  localparam logic [ADDR_W-1:0] A_GEN  = ADDR_W'(NPIN + OFS_GEN);

  logic [BUS_W-1:0] rd_mux;

  // per-pin strength code registers
  for (genvar i = 0; i < NPIN; i++) begin : g_code
    always_ff @(posedge clk) begin
      if (rst) begin
        code_flat[i*CODE_W +: CODE_W] <= '0;
      end else if (wr_en && addr == ADDR_W'(i)) begin
        code_flat[i*CODE_W +: CODE_W] <= wdata[CODE_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '1;
      ien_q  <= '0;
      pol_q  <= '0;
      gen_q  <= 1'b0;
    end else if (wr_en) begin
      if (addr == A_DATA) data_q <= wdata[NPIN-1:0];
      if (addr == A_IEN)  ien_q  <= wdata[NPIN-1:0];
      if (addr == A_POL)  pol_q  <= wdata[NPIN-1:0];
      if (addr == A_GEN)  gen_q  <= wdata[0];
    end
  end

  always_comb begin
    clr_o = '0;
    if (wr_en && addr == A_PEND) clr_o = wdata[NPIN-1:0];
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NPIN; i++) begin
      if (addr == ADDR_W'(i)) rd_mux = BUS_W'(code_flat[i*CODE_W +: CODE_W]);
    end
    case (addr)
      A_DATA:  rd_mux = BUS_W'(data_q);
      A_IEN:   rd_mux = BUS_W'(ien_q);
      A_POL:   rd_mux = BUS_W'(pol_q);
      A_PEND:  rd_mux = BUS_W'(pend_i);
      A_LVL:   rd_mux = BUS_W'(lvl_i);
      A_GEN:   rd_mux = BUS_W'(gen_q);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
    else            rdata <= '0;
  end
endmodule

// File: rtl/sink_port_edge.sv
module sink_port_edge #(
  parameter int NPIN   = 8,
  parameter int SYNC_N = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] pin_i,
  input  logic [NPIN-1:0] pol_i,
  input  logic [NPIN-1:0] clr_i,
  output logic [NPIN-1:0] lvl_o,
  output logic [NPIN-1:0] pend_o
);
  logic [NPIN-1:0] stg [SYNC_N];
  logic [NPIN-1:0] prev_q;
  logic [NPIN-1:0] hit;

  assign lvl_o = stg[SYNC_N-1];

  // rising edge for polarity 1, falling edge for polarity 0
  assign hit = (pol_i & lvl_o & ~prev_q) | (~pol_i & ~lvl_o & prev_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < SYNC_N; k++) stg[k] <= '1;
      prev_q <= '1;
      pend_o <= '0;
    end else begin
      stg[0] <= pin_i;
      for (int k = 1; k < SYNC_N; k++) stg[k] <= stg[k-1];
      prev_q <= lvl_o;
      pend_o <= (pend_o & ~clr_i) | hit;
    end
  end
endmodule

// File: rtl/sink_port_drive.sv
module sink_port_drive #(
  parameter int NPIN    = 8,
  parameter int CODE_W  = 4,
  parameter int HI_PINS = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NPIN-1:0]        data_i,
  input  logic [NPIN*CODE_W-1:0] code_i,
  output logic [NPIN-1:0]        pu_en,
  output logic [NPIN-1:0]        snk_en,
  output logic [NPIN*CODE_W-1:0] snk_code,
  output logic [NPIN-1:0]        hi_range
);
  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    localparam bit IS_HI = (i < HI_PINS);
    assign hi_range[i] = IS_HI;

    always_ff @(posedge clk) begin
      if (rst) begin
        pu_en[i]                     <= 1'b1;
        snk_en[i]                    <= 1'b0;
        snk_code[i*CODE_W +: CODE_W] <= '0;
      end else begin
        pu_en[i]                     <= data_i[i];
        snk_en[i]                    <= ~data_i[i];
        snk_code[i*CODE_W +: CODE_W] <= code_i[i*CODE_W +: CODE_W];
      end
    end
  end
endmodule

// File: rtl/sink_port_ctrl.sv
module sink_port_ctrl
  import sink_port_pkg::*;
#(
  parameter int NPIN    = 8,
  parameter int CODE_W  = 4,
  parameter int BUS_W   = 8,
  parameter int HI_PINS = 2,
  parameter int SYNC_N  = 2,
  localparam int ADDR_W = addr_bits(NPIN)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [BUS_W-1:0]       wdata,
  output logic [BUS_W-1:0]       rdata,
  input  logic [NPIN-1:0]        pin_in,
  output logic [NPIN-1:0]        pu_en,
  output logic [NPIN-1:0]        snk_en,
  output logic [NPIN*CODE_W-1:0] snk_code,
  output logic [NPIN-1:0]        hi_range,
  output logic                   irq
);
  logic [NPIN-1:0]        data_q, ien_q, pol_q, clr, lvl, pend_q;
  logic                   gen_q;
  logic [NPIN*CODE_W-1:0] code_flat;

  sink_port_regs #(
    .NPIN(NPIN), .CODE_W(CODE_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .lvl_i(lvl), .pend_i(pend_q), .data_q(data_q),
    .ien_q(ien_q), .pol_q(pol_q), .gen_q(gen_q), .clr_o(clr),
    .code_flat(code_flat), .rdata(rdata)
  );

  sink_port_edge #(
    .NPIN(NPIN), .SYNC_N(SYNC_N)
  ) u_edge (
    .clk(clk), .rst(rst), .pin_i(pin_in), .pol_i(pol_q), .clr_i(clr),
    .lvl_o(lvl), .pend_o(pend_q)
  );

  sink_port_drive #(
    .NPIN(NPIN), .CODE_W(CODE_W), .HI_PINS(HI_PINS)
  ) u_drive (
    .clk(clk), .rst(rst), .data_i(data_q), .code_i(code_flat),
    .pu_en(pu_en), .snk_en(snk_en), .snk_code(snk_code), .hi_range(hi_range)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= gen_q & (|(pend_q & ien_q));
  end
endmodule

// File: rtl/sink_port_chk.sv
module sink_port_chk #(
  parameter int NPIN   = 8,
  parameter int CODE_W = 4,
  parameter int BUS_W  = 8,
  parameter int ADDR_W = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   wr_en,
  input logic                   rd_en,
  input logic [ADDR_W-1:0]      addr,
  input logic [BUS_W-1:0]       wdata,
  input logic [BUS_W-1:0]       rdata,
  input logic [NPIN-1:0]        pu_en,
  input logic [NPIN-1:0]        snk_en,
  input logic [NPIN*CODE_W-1:0] snk_code,
  input logic                   irq,
  input logic [NPIN-1:0]        pend_q,
  input logic                   gen_q
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(NPIN);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(NPIN + 3);

  // R3
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pu_en == '1 && snk_en == '0 && snk_code == '0 && !irq));

  // R1
  pullup_on_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_DATA) |-> ##2 (pu_en == $past(wdata[NPIN-1:0], 2)));

  // R2
  sink_on_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_DATA) |-> ##2 (snk_en == ~$past(wdata[NPIN-1:0], 2)));

  // R4
  code_out_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr < ADDR_W'(NPIN)) |-> ##2
      (snk_code[int'($past(addr, 2))*CODE_W +: CODE_W] == $past(wdata[CODE_W-1:0], 2)));

  // R8
  pend_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (|($past(pend_q) & ~pend_q)) |-> $past(wr_en && addr == A_PEND));

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(gen_q) |-> !irq);

  // R10
  rdata_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en) |-> (rdata == '0));
endmodule

bind sink_port_ctrl sink_port_chk #(
  .NPIN(NPIN), .CODE_W(CODE_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .pu_en(pu_en), .snk_en(snk_en),
  .snk_code(snk_code), .irq(irq), .pend_q(pend_q), .gen_q(gen_q)
);

// File: tb/sim_sink_port_ctrl.sv
module sim_sink_port_ctrl;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0, rdata;
  logic [7:0]  pin_in = 8'hFF;
  logic [7:0]  pu_en, snk_en, hi_range;
  logic [31:0] snk_code;
  logic        irq;

  int errors = 0, checks = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  sink_port_ctrl u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pu_en(pu_en),
    .snk_en(snk_en), .snk_code(snk_code), .hi_range(hi_range), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  logic [7:0]  m_data, m_ien, m_pol, m_pend, m_pu, m_sk, m_rd;
  logic        m_gen, m_irq;
  logic [3:0]  m_code [8];
  logic [31:0] m_code_o;
  logic [7:0]  hist [$];

  always @(posedge clk) begin
    logic [7:0] rise, fall, setv, clrv, nrd;
    if (rst) begin
      m_data = 8'hFF; m_ien = 0; m_pol = 0; m_pend = 0; m_gen = 0; m_irq = 0;
      m_pu = 8'hFF; m_sk = 0; m_rd = 0; m_code_o = 0;
      foreach (m_code[i]) m_code[i] = 0;
      hist = {8'hFF, 8'hFF, 8'hFF};
    end else begin
      rise = hist[1] & ~hist[2];
      fall = ~hist[1] & hist[2];
      setv = (m_pol & rise) | (~m_pol & fall);
      nrd = 0;
      if (rd_en) begin
        if (addr < 8) nrd = {4'h0, m_code[addr]};
        else case (addr)
          8:  nrd = m_data;
          9:  nrd = m_ien;
          10: nrd = m_pol;
          11: nrd = m_pend;
          12: nrd = hist[1];
          13: nrd = {7'h0, m_gen};
          default: nrd = 0;
        endcase
      end
      m_rd  = nrd;
      m_irq = m_gen && ((m_pend & m_ien) != 0);
      m_pu  = m_data;
      m_sk  = ~m_data;
      for (int i = 0; i < 8; i++) m_code_o[i*4 +: 4] = m_code[i];
      clrv = (wr_en && addr == 11) ? wdata : 8'h00;
      if (wr_en) begin
        if (addr < 8) m_code[addr] = wdata[3:0];
        if (addr == 8)  m_data = wdata;
        if (addr == 9)  m_ien  = wdata;
        if (addr == 10) m_pol  = wdata;
        if (addr == 13) m_gen  = wdata[0];
      end
      m_pend = (m_pend & ~clrv) | setv;
      hist.push_front(pin_in);
      void'(hist.pop_back());
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every cycle against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R1 pu_en", pu_en, m_pu);
      chk("R2 snk_en", snk_en, m_sk);
      chk("R4 snk_code", snk_code, m_code_o);
      chk("R5 hi_range", hi_range, 8'h03);
      chk("R9 irq", irq, m_irq);
      chk("R10 rdata", rdata, m_rd);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0;
    chk(tag, rdata, exp);
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    wait_cyc(3);
    rst = 0;
    @(negedge clk);
    // R3 reset state
    chk("R3 pu_en", pu_en, 8'hFF);
    chk("R3 snk_en", snk_en, 8'h00);
    chk("R3 snk_code", snk_code, 32'h0);
    chk("R3 irq", irq, 1'b0);
    rd_chk(4'd8, 8'hFF, "R3 data");
    rd_chk(4'd10, 8'h00, "R3 pol");
    rd_chk(4'd3, 8'h00, "R3 code");
    // R4 strength codes, upper nibble ignored
    for (int i = 0; i < 8; i++) wr(4'(i), 8'hF0 | 8'(i + 3));
    rd_chk(4'd2, 8'h05, "R4 code2 readback");
    chk("R4 code7 out", snk_code[31:28], 4'hA);
    chk("R5 range", hi_range, 8'h03);
    // R1/R2 drive
    wr(4'd8, 8'h5A);
    wait_cyc(1);
    chk("R1 pullup", pu_en, 8'h5A);
    chk("R2 sink", snk_en, 8'hA5);
    // R7 polarity
    wr(4'd10, 8'h0F);
    wr(4'd9, 8'hFF);
    wr(4'd13, 8'h01);
    pin_in = 8'hF0;
    wait_cyc(5);
    rd_chk(4'd11, 8'h00, "R7 wrong edge ignored");
    chk("R9 no irq", irq, 1'b0);
    rd_chk(4'd12, 8'hF0, "R6 level");
    pin_in = 8'hFF;
    wait_cyc(5);
    rd_chk(4'd11, 8'h0F, "R7 rising edges");
    chk("R9 irq set", irq, 1'b1);
    // R8 write-one-to-clear
    wr(4'd11, 8'h03);
    rd_chk(4'd11, 8'h0C, "R8 partial clear");
    wr(4'd11, 8'h0C);
    wait_cyc(1);
    chk("R9 irq cleared", irq, 1'b0);
    // R9 global gate
    wr(4'd13, 8'h00);
    pin_in = 8'h0F;
    wait_cyc(5);
    rd_chk(4'd11, 8'hF0, "R8 falling set");
    chk("R9 global off", irq, 1'b0);
    wr(4'd13, 8'h01);
    wait_cyc(1);
    chk("R9 global on", irq, 1'b1);
    wr(4'd9, 8'h0F);
    wait_cyc(1);
    chk("R9 masked", irq, 1'b0);
    // R10 unmapped
    wr(4'd14, 8'hFF);
    rd_chk(4'd14, 8'h00, "R10 unmapped 14");
    rd_chk(4'd15, 8'h00, "R10 unmapped 15");
    rd_chk(4'd13, 8'h01, "R10 gen read");
    // random phase, model compared every clock
    for (int n = 0; n < 2000; n++) begin
      @(negedge clk);
      wr_en = ($urandom % 3) == 0;
      rd_en = ($urandom % 2) == 0;
      addr  = 4'($urandom);
      wdata = 8'($urandom);
      if (($urandom % 4) == 0) pin_in = pin_in ^ 8'($urandom);
    end
    @(negedge clk); wr_en = 0; rd_en = 0;
    wait_cyc(4);
    finish_run();
  end
endmodule